// File: doc/BRIEF.md
# Per-Channel Receive Code Substitution

This stage sits on the receive serial path of a 24-channel, 193-bit frame. Each frame opens with one framing bit. Then come 24 channels of 8 bits each, sent most significant bit first. For every channel whose mark bit is set, the stage discards the incoming byte and sends a substitute byte instead. The substitute is either a fixed idle byte or the current byte of an eight-byte tone sequence that represents a 1 kHz sine. Unmarked channels and the framing bit pass through untouched.

The stage keeps its own bit position within the frame. A frame-start strobe, given together with the bit enable on the framing bit, sets that position. One global select input chooses between the idle byte and the tone sequence. The tone sequence is shared by all marked channels and steps by one byte per frame. The output is registered, so it trails the input by exactly one bit period in every case.

Top module: `rx_chan_subst`

## Requirements
- R1: While `tone_sel` is 0, every bit of a marked channel is replaced by the idle byte 0x7F, most significant bit first.
- R2: While `tone_sel` is 1, a marked channel carries the current tone byte, most significant bit first. The tone sequence is 0x1E, 0x0B, 0x0B, 0x1E, 0x9E, 0x8B, 0x8B, 0x9E, and the first frame after reset uses 0x1E.
- R3: The tone index is shared by all marked channels of a frame. It advances by one after the last bit of channel 24 and wraps after eight frames.
- R4: A channel whose mark bit is 0 passes its input bits through unchanged. Channel n (1 to 24) uses bit n-1 of `chan_mark`.
- R5: The framing bit is never replaced. Until the first frame start after reset, every bit passes through unchanged.
- R6: `dout` takes the processed bit on the clock edge that accepts the input bit (bit_en high), so the latency is one bit period. `dout` holds its value on cycles where bit_en is low.
- R7: The mark bit and `tone_sel` are sampled on the first bit of each channel. Changes during the remaining seven bits have no effect until the next channel.
- R8: `frame_start` with `bit_en` marks the framing bit and realigns the bit count even in the middle of a frame. After reset, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_en | input | 1 | Accepts one serial bit this cycle |
| frame_start | input | 1 | With bit_en: this bit is the framing bit |
| din | input | 1 | Incoming serial data |
| chan_mark | input | 24 | Per-channel substitution enable |
| tone_sel | input | 1 | 0: idle byte, 1: tone sequence |
| dout | output | 1 | Processed serial data |

## Verification
Every result lands on the clock edge where `bit_en` accepts the corresponding input bit. The bench therefore drives each bit at a falling edge and compares `dout` with the reference model at the next falling edge. It then checks again one idle cycle later, to confirm that the value was held. The tone index changes after the edge that takes bit 192, so the model steps its index right after computing that bit. The first channel-1 bit of the next frame is then checked against the new tone byte. For mid-byte changes to the mark and select inputs, the bench applies the change together with a bit. Those changes are expected to show only from the next channel's first bit.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam logic [7:0] IDLE_CODE = 8'h7F;
    localparam int TONE_LEN = 8;

    function automatic logic [7:0] tone_byte(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd3: tone_byte = 8'h1E;
            3'd1, 3'd2: tone_byte = 8'h0B;
            3'd4, 3'd7: tone_byte = 8'h9E;
            default:    tone_byte = 8'h8B;
        endcase
    endfunction
endpackage

// File: rtl/rxs_slot_track.sv
module rxs_slot_track #(
    parameter int NUM_CHAN  = 24,
    parameter int CHAN_BITS = 8,
    localparam int FRAME_BITS = 1 + NUM_CHAN * CHAN_BITS,
    localparam int POS_W = $clog2(FRAME_BITS),
    localparam int CH_W  = $clog2(NUM_CHAN),
    localparam int BI_W  = $clog2(CHAN_BITS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bit_en,
    input  logic            frame_start,
    output logic            in_chan,
    output logic [CH_W-1:0] chan_idx,
    output logic [BI_W-1:0] bit_idx,
    output logic            frame_end
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             synced;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [POS_W-1:0] cur_pos;
    logic [POS_W-1:0] off;
    logic             synced_now;

    always_comb begin
        cur_pos    = frame_start ? '0 : trk_q.pos;
        synced_now = trk_q.synced | frame_start;
        off        = cur_pos - POS_W'(1);
        in_chan    = synced_now && (cur_pos != '0);
        chan_idx   = CH_W'(off / POS_W'(CHAN_BITS));
        bit_idx    = BI_W'(off % POS_W'(CHAN_BITS));
        frame_end  = synced_now && (cur_pos == POS_W'(FRAME_BITS - 1));
        trk_d = trk_q;
        if (bit_en) begin
            trk_d.synced = synced_now;
            trk_d.pos = (cur_pos == POS_W'(FRAME_BITS - 1)) ? '0 : cur_pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end
endmodule

// File: rtl/rxs_tone_seq.sv
module rxs_tone_seq #(
    parameter int SEQ_LEN = 8,
    localparam int IDX_W = $clog2(SEQ_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (advance)
            idx_d = (idx_q == IDX_W'(SEQ_LEN - 1)) ? '0 : idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/rx_chan_subst.sv
module rx_chan_subst #(
    parameter int NUM_CHAN  = 24,
    parameter int CHAN_BITS = 8,
    localparam int CH_W = $clog2(NUM_CHAN),
    localparam int BI_W = $clog2(CHAN_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                frame_start,
    input  logic                din,
    input  logic [NUM_CHAN-1:0] chan_mark,
    input  logic                tone_sel,
    output logic                dout
);
    import rxs_pkg::*;

    typedef struct packed {
        logic mark;
        logic sel;
        logic dout;
    } out_t;

    out_t st_d, st_q;

    logic            in_chan;
    logic [CH_W-1:0] chan_idx;
    logic [BI_W-1:0] bit_idx;
    logic            frame_end;
    logic [2:0]      tone_idx;
    logic            mark_now;
    logic            sel_now;
    logic            subst;
    logic [7:0]      code;

    rxs_slot_track #(.NUM_CHAN(NUM_CHAN), .CHAN_BITS(CHAN_BITS)) u_trk (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .in_chan(in_chan), .chan_idx(chan_idx), .bit_idx(bit_idx), .frame_end(frame_end)
    );

    rxs_tone_seq #(.SEQ_LEN(TONE_LEN)) u_tone (
        .clk(clk), .rst_n(rst_n), .advance(bit_en && frame_end), .idx(tone_idx)
    );

    always_comb begin
        st_d     = st_q;
        mark_now = (bit_idx == '0) ? chan_mark[chan_idx] : st_q.mark;
        sel_now  = (bit_idx == '0) ? tone_sel : st_q.sel;
        subst    = in_chan && mark_now;
        code     = sel_now ? tone_byte(tone_idx) : IDLE_CODE;
        if (bit_en) begin
            if (in_chan) begin
                st_d.mark = mark_now;
                st_d.sel  = sel_now;
            end
            st_d.dout = subst ? code[3'(CHAN_BITS - 1) - 3'(bit_idx)] : din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.dout;
endmodule

module rx_chan_subst_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       frame_start,
    input logic       din,
    input logic       dout,
    input logic       subst,
    input logic       sel_now,
    input logic [2:0] bit_idx,
    input logic       frame_end,
    input logic [2:0] tone_idx
);
    logic idle_bit;
    assign idle_bit = rxs_pkg::IDLE_CODE[3'd7 - bit_idx];

    p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !subst |=> dout == $past(din));
    p_frame_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && frame_start |=> dout == $past(din));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(dout));
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && subst && !sel_now |=> dout == $past(idle_bit));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && frame_end |=> tone_idx == $past(tone_idx) + 3'd1);
    p_no_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_en && frame_end) |=> $stable(tone_idx));
endmodule

bind rx_chan_subst rx_chan_subst_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
    .din(din), .dout(dout), .subst(subst), .sel_now(sel_now),
    .bit_idx(3'(bit_idx)), .frame_end(frame_end), .tone_idx(tone_idx)
);

// File: tb/tb_rx_chan_subst.sv
module tb_rx_chan_subst;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bit_en = 0;
    logic        frame_start = 0;
    logic        din = 0;
    logic [23:0] chan_mark = '0;
    logic        tone_sel = 0;
    logic        dout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int   m_pos = 0;
    bit   m_sync = 0;
    int   m_idx = 0;
    bit   m_mark = 0;
    bit   m_sel = 0;
    logic m_exp = 0;
    string m_tag = "R8";
    bit   phase_mid = 0;

    byte unsigned tone_tab[8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};

    rx_chan_subst dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .din(din), .chan_mark(chan_mark), .tone_sel(tone_sel), .dout(dout)
    );

    always #10 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dout=%b expected %b (time %0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: position, sync, latched mark/select, tone index.
    task automatic model_step(input bit fs, input logic d);
        int ch, b;
        byte unsigned code;
        if (fs) begin m_pos = 0; m_sync = 1; end
        if (m_sync && m_pos > 0) begin
            ch = (m_pos - 1) / 8;
            b  = (m_pos - 1) % 8;
            if (b == 0) begin m_mark = chan_mark[ch]; m_sel = tone_sel; end
            if (m_mark) begin
                code  = m_sel ? tone_tab[m_idx] : 8'h7F;
                m_exp = code[7 - b];
                m_tag = m_sel ? "R2/R3" : "R1";
            end else begin
                m_exp = d;
                m_tag = "R4";
            end
            if (phase_mid) m_tag = {m_tag, " R7"};
        end else begin
            m_exp = d;
            m_tag = fs ? "R5 R8" : "R5";
        end
        if (m_sync && m_pos == 192) m_idx = (m_idx + 1) % 8;
        m_pos = (m_pos == 192) ? 0 : m_pos + 1;
    endtask

    task automatic send_bit(input bit fs, input logic d);
        @(negedge clk);
        bit_en = 1; frame_start = fs; din = d;
        model_step(fs, d);
        @(negedge clk);
        bit_en = 0; frame_start = 0;
        check(dout, m_exp, m_tag);
        din = ~d;
        @(negedge clk);
        check(dout, m_exp, "R6");
    endtask

    task automatic send_frame(input int nbits, input bit churn);
        for (int i = 0; i < nbits; i++) begin
            if (churn) begin
                chan_mark = $urandom;
                tone_sel  = $urandom;
            end
            send_bit(i == 0, $urandom);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(dout, 1'b0, "R8");
        rst_n = 1;
        // R5: bits before first frame start pass through
        for (int i = 0; i < 20; i++) send_bit(0, $urandom);
        // R1/R4: idle on alternating channels
        chan_mark = 24'h55AA33; tone_sel = 0;
        send_frame(193, 0);
        chan_mark = 24'hFFFFFF;
        send_frame(193, 0);
        // R2/R3: tone across more than eight frames
        tone_sel = 1; chan_mark = 24'h800001;
        for (int f = 0; f < 9; f++) send_frame(193, 0);
        // R7: mark and select change on every bit
        phase_mid = 1;
        for (int f = 0; f < 2; f++) send_frame(193, 1);
        phase_mid = 0;
        // R8: early realignment in mid frame
        chan_mark = 24'h0F0F0F; tone_sel = 0;
        send_frame(100, 0);
        send_frame(193, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, got hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule